// File: doc/BRIEF.md
# MDIO Management Bus Controller

This block sits on a simple register bus and runs management frames on a two-wire serial bus (MDC clock, MDIO data) so that software can reach registers inside external or on-chip PHY devices. Software stores a PHY address and a register number in an address register. A write frame starts when software writes the 16-bit value to send. A read frame starts when the read-command bit changes from 0 to 1. Software then polls an indicator register until the frame is finished. After a read, it collects the 16 captured bits from a read-only result register.

Each frame is 64 bit-times long and is sent MSB first: 32 ones, start `01`, opcode (`01` write, `10` read), five PHY-address bits, five register-number bits, a two-bit turnaround, and 16 data bits. MDC runs only while a frame is active, with a period of 2*(divider+1) system clocks. A soft reset written to the configuration register sends the engine back to idle within one clock. It does not change the stored divider.

Register word offsets on `bus_addr`: 0 configuration, 1 command, 2 address, 3 write data, 4 read result, 5 indicator.

Top module: `mdio_ctrl`

## Requirements
- R1: The address register (offset 2) holds the PHY address in bits [12:8] and the register number in bits [4:0]. Both fields go into every frame, PHY address first, each MSB first.
- R2: A bus write to offset 3 while idle starts a write frame carrying bits [15:0] of the written value. The frame is 32 ones, then 01, 01, PHY, register, turnaround 10, and the data MSB first. MDIO is driven for all 64 bits.
- R3: A read frame starts only when command bit 0 (offset 1) is written as 1 while its stored value is 0. Writing 1 again while the bit is already 1 starts nothing.
- R4: Indicator bit 0 (busy, offset 5) rises on the clock edge that accepts a launch. It stays set for exactly 128*(divider+1) clocks, which is the whole frame. It reads 0 after reset.
- R5: Indicator bit 1 (not-valid) is set with busy when a read launches. It clears on the same edge as busy, when the 16th data bit has been captured. At that edge the read-result register (offset 4, bits [15:0]) takes the captured value.
- R6: A read frame uses opcode 10. It releases MDIO (output enable low) from the first turnaround bit through the last data bit. It samples MDIO as MDC rises. Output enable is low whenever the bus is idle.
- R7: MDC is low when idle and has a period of 2*(divider+1) clocks during a frame. The divider is configuration bits [7:0], and its reset value is 24.
- R8: Writing the configuration register with bit 31 set aborts any frame: busy, not-valid, MDC and output enable are all low on the next clock. The divider keeps its value. A configuration write with bit 31 clear loads bits [7:0] as the new divider.
- R9: A write to offset 3, or a 0-to-1 read command, that arrives while busy is ignored. The frame in progress completes unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
Busy and not-valid appear on the clock edge that accepts a launch. The bench therefore reads the indicator at the falling edge just after its write strobe. It then counts the falling edges on which busy is still high and compares that count with 128*(divider+1). At that same falling edge it checks that busy has dropped, that not-valid has dropped, and that the read result is already present. Frame bits are taken at the first falling clock edge after each MDC rise, which is inside the high phase where MDIO is stable. The bench's PHY model changes its MDIO input at the first falling clock edge after an MDC fall, at least one clock before the next sample. An abort is checked at the falling edge right after the configuration write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_AW      = 3;
    localparam int FRAME_BITS  = 64;
    localparam int POS_W       = $clog2(FRAME_BITS);
    localparam int PRE_BITS    = 32;
    localparam int TA_POS      = 46;
    localparam int DATA_POS    = 48;
    localparam int PHY_W       = 5;
    localparam int REGN_W      = 5;
    localparam int DATA_W      = 16;
    localparam int PHY_LSB     = 8;
    localparam int REGN_LSB    = 0;
    localparam int CFG_RST_BIT = 31;
    localparam int CMD_RD_BIT  = 0;
    localparam int IND_BUSY    = 0;
    localparam int IND_NV      = 1;

    typedef enum logic [REG_AW-1:0] {
        A_CFG   = 3'd0,
        A_CMD   = 3'd1,
        A_ADDR  = 3'd2,
        A_WDATA = 3'd3,
        A_RDATA = 3'd4,
        A_IND   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e            op;
        logic [PHY_W-1:0]    phy;
        logic [REGN_W-1:0]   regn;
        logic [DATA_W-1:0]   data;
    } mdio_req_t;

    // Full 64-bit serial image, first bit on the wire at the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t q);
        logic [1:0] ta;
        ta = (q.op == OP_RD) ? 2'b11 : 2'b10;
        return {{PRE_BITS{1'b1}}, 2'b01, q.op, q.phy, q.regn, ta, q.data};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             expire;

    // >= so that a divider lowered mid-phase still ends the phase
    assign expire = run && (cnt >= div);
    assign rise   = expire && !mdc;
    assign fall   = expire && mdc;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (expire) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              is_rd,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rx_data
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] TA_P     = POS_W'(TA_POS);
    localparam logic [POS_W-1:0] DATA_P   = POS_W'(DATA_POS);

    logic [FRAME_BITS-1:0] sh;
    logic [POS_W-1:0]      pos;

    assign done    = busy && fall && (pos == LAST_POS);
    assign mdio_o  = sh[FRAME_BITS-1];
    assign mdio_oe = busy && !(is_rd && (pos >= TA_P));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy  <= 1'b0;
            is_rd <= 1'b0;
            pos   <= '0;
            sh    <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            is_rd <= (req.op == OP_RD);
            pos   <= '0;
            sh    <= build_frame(req);
        end else if (busy && fall) begin
            if (pos == LAST_POS) begin
                busy <= 1'b0;
            end else begin
                pos <= pos + 1'b1;
                sh  <= {sh[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Capture on the MDC rising edge during the data phase of a read
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
        end else if (busy && rise && is_rd && (pos >= DATA_P)) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              busy,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DIV_W-1:0]  div,
    output logic              abort,
    output logic              start,
    output mdio_req_t         req,
    output logic              nv
);
    reg_addr_e          sel;
    logic               wr_cfg, wr_cmd, wr_addr, wr_data;
    logic               go_wr, go_rd;
    logic               cmd_q;
    logic [PHY_W-1:0]   phy_q;
    logic [REGN_W-1:0]  regn_q;
    logic [DATA_W-1:0]  wd_q, rd_q;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign sel     = reg_addr_e'(bus_addr);
    assign wr_cfg  = bus_we && (sel == A_CFG);
    assign wr_cmd  = bus_we && (sel == A_CMD);
    assign wr_addr = bus_we && (sel == A_ADDR);
    assign wr_data = bus_we && (sel == A_WDATA);

    assign abort = wr_cfg && bus_wdata[CFG_RST_BIT];
    assign go_wr = wr_data && !busy;
    assign go_rd = wr_cmd && bus_wdata[CMD_RD_BIT] && !cmd_q && !busy;
    assign start = go_wr || go_rd;

    always_comb begin
        req.op   = go_rd ? OP_RD : OP_WR;
        req.phy  = phy_q;
        req.regn = regn_q;
        req.data = go_wr ? bus_wdata[DATA_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div    <= DIV_W'(DIV_RST);
            cmd_q  <= 1'b0;
            phy_q  <= '0;
            regn_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            nv     <= 1'b0;
        end else begin
            if (wr_cfg && !bus_wdata[CFG_RST_BIT]) div <= bus_wdata[DIV_W-1:0];
            if (wr_cmd)  cmd_q <= bus_wdata[CMD_RD_BIT];
            if (wr_addr) begin
                phy_q  <= bus_wdata[PHY_LSB +: PHY_W];
                regn_q <= bus_wdata[REGN_LSB +: REGN_W];
            end
            if (go_wr)   wd_q <= bus_wdata[DATA_W-1:0];
            if (rx_done) rd_q <= rx_data;
            if (abort || rx_done) nv <= 1'b0;
            else if (go_rd)       nv <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            A_CFG:   bus_rdata[DIV_W-1:0] = div;
            A_CMD:   bus_rdata[CMD_RD_BIT] = cmd_q;
            A_ADDR: begin
                bus_rdata[PHY_LSB +: PHY_W]   = phy_q;
                bus_rdata[REGN_LSB +: REGN_W] = regn_q;
            end
            A_WDATA: bus_rdata[DATA_W-1:0] = wd_q;
            A_RDATA: bus_rdata[DATA_W-1:0] = rd_q;
            A_IND: begin
                bus_rdata[IND_BUSY] = busy;
                bus_rdata[IND_NV]   = nv;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int DW      = 32,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy, nv, abort, start;
    logic              is_rd, done, rise, fall;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] rx_data;
    mdio_req_t         req;

    mdio_regs #(.DW(DW), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rx_done(done && is_rd), .rx_data(rx_data), .div(div),
        .abort(abort), .start(start), .req(req), .nv(nv)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .clr(abort), .run(busy), .div(div),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_frame u_frame (
        .clk(clk), .rst(rst), .abort(abort), .start(start), .req(req),
        .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy),
        .is_rd(is_rd), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rx_data(rx_data)
    );
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              nv,
    input logic              abort,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DIV_W-1:0]  div
);
    logic [31:0] len_cnt;
    logic        div_moved;
    logic [31:0] exp_len;

    assign exp_len = (32'(div) + 32'd1) << 7;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_cnt   <= '0;
            div_moved <= 1'b0;
        end else begin
            len_cnt   <= busy ? len_cnt + 32'd1 : 32'd0;
            div_moved <= busy ? (div_moved || (bus_we && bus_addr == REG_AW'(A_CFG))) : 1'b0;
        end
    end

    // R7
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R6
    oe_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    // R5
    nv_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        nv |-> busy);

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !nv && !mdc));

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(abort) && !div_moved) |-> (len_cnt == exp_len));
endmodule

bind mdio_ctrl mdio_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .nv(nv), .abort(abort), .mdc(mdc),
    .mdio_oe(mdio_oe), .bus_we(bus_we), .bus_addr(bus_addr), .div(div)
);

// File: tb/mdio_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int r = 0;
    int rise_t[2];
    logic cap_o[64];
    logic cap_oe[64];
    logic mdc_q = 1'b0;
    logic [15:0] phy_data = 16'h0;

    mdio_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // Bus observer and PHY model, away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mdc && !mdc_q) begin
            if (r < 64) begin
                cap_o[r]  = mdio_o;
                cap_oe[r] = mdio_oe;
            end
            if (r < 2) rise_t[r] = cyc;
            r = r + 1;
        end
        if (!mdc && mdc_q) begin
            mdio_i = (r >= 48 && r < 64) ? phy_data[63 - r] : 1'b1;
        end
        mdc_q = mdc;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        reg_rd(3'd5, v);
        while (v[0]) begin
            n++;
            @(negedge clk);
            reg_rd(3'd5, v);
        end
    endtask

    function automatic logic exp_bit(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] d, input int i);
        if (i < 32) return 1'b1;
        if (i == 32) return 1'b0;
        if (i == 33) return 1'b1;
        if (i == 34) return rd;
        if (i == 35) return !rd;
        if (i <= 40) return phy[40 - i];
        if (i <= 45) return rg[45 - i];
        if (i == 46) return 1'b1;
        if (i == 47) return 1'b0;
        return d[63 - i];
    endfunction

    task automatic check_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] d, input string req);
        int bad = -1;
        for (int i = 0; i < 64; i++) begin
            logic eoe;
            eoe = !(rd && i >= 46);
            if (cap_oe[i] !== eoe) begin
                if (bad < 0) bad = i;
            end else if (eoe && cap_o[i] !== exp_bit(rd, phy, rg, d, i)) begin
                if (bad < 0) bad = i;
            end
        end
        check(r == 64, {req, " bit count"}, r, 64);
        check(bad < 0, {req, " frame bit"}, bad, 32'hffffffff);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                            input int dv, input string req);
        int n;
        reg_wr(3'd2, {19'd0, phy, 3'd0, rg});
        r = 0;
        reg_wr(3'd3, {16'd0, d});
        wait_idle(n);
        check(n == 128 * (dv + 1), {req, " busy length"}, n, 128 * (dv + 1));
        check_frame(1'b0, phy, rg, d, req);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pd,
                           input int dv);
        int n;
        logic [31:0] v;
        phy_data = pd;
        reg_wr(3'd2, {19'd0, phy, 3'd0, rg});
        reg_wr(3'd1, 32'd0);
        r = 0;
        reg_wr(3'd1, 32'd1);
        reg_rd(3'd5, v);
        check(v[1:0] == 2'b11, "R5 not-valid and busy at launch", v, 3);
        wait_idle(n);
        check(n == 128 * (dv + 1), "R4 read busy length", n, 128 * (dv + 1));
        reg_rd(3'd5, v);
        check(v[1] == 1'b0, "R5 not-valid clear at end", v, 0);
        reg_rd(3'd4, v);
        check(v == {16'd0, pd}, "R5 read result", v, {16'd0, pd});
        check_frame(1'b1, phy, rg, 16'd0, "R6/R1 read");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        reg_rd(3'd5, v);
        check(v == 0, "R4 indicator after reset", v, 0);
        reg_rd(3'd0, v);
        check(v == 24, "R7 default divider", v, 24);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R6/R7 idle pins", {mdc, mdio_oe}, 0);

        // Default divider frame
        do_write(5'h15, 5'h0A, 16'hA55A, 24, "R2/R4 default-div write");

        // R8: divider load
        reg_wr(3'd0, 32'd1);
        reg_rd(3'd0, v);
        check(v == 1, "R8 divider load", v, 1);

        for (int k = 0; k < 6; k++) begin
            logic [4:0] p, g;
            logic [15:0] d;
            p = 5'($urandom); g = 5'($urandom); d = 16'($urandom);
            if (k == 0) begin p = 5'h1F; g = 5'h1F; d = 16'hFFFF; end
            if (k == 1) begin p = 5'h00; g = 5'h00; d = 16'h0000; end
            do_write(p, g, d, 1, "R1/R2 write");
        end

        for (int k = 0; k < 6; k++) begin
            logic [15:0] pd;
            pd = 16'($urandom);
            if (k == 0) pd = 16'h8001;
            do_read(5'($urandom), 5'($urandom), pd, 1);
        end

        // R3: command already 1, writing 1 again launches nothing
        r = 0;
        reg_wr(3'd1, 32'd1);
        repeat (10) @(negedge clk);
        reg_rd(3'd5, v);
        check(v == 0, "R3 no relaunch without 0-to-1", v, 0);
        check(r == 0, "R3 MDC stays idle", r, 0);

        // R9: launches while busy are ignored
        reg_wr(3'd1, 32'd0);
        reg_wr(3'd2, {19'd0, 5'h09, 3'd0, 5'h12});
        r = 0;
        reg_wr(3'd3, 32'h0000_1234);
        repeat (30) @(negedge clk);
        reg_wr(3'd3, 32'h0000_ABCD);
        reg_wr(3'd1, 32'd1);
        wait_idle(n);
        check_frame(1'b0, 5'h09, 5'h12, 16'h1234, "R9 frame undisturbed");
        reg_rd(3'd5, v);
        check(v == 0, "R9 no read launched", v, 0);
        repeat (20) @(negedge clk);
        reg_rd(3'd5, v);
        check(v == 0 && r == 64, "R9 no follow-up frame", r, 64);
        reg_wr(3'd1, 32'd0);

        // R7: MDC period with divider 3
        reg_wr(3'd0, 32'd3);
        do_write(5'h03, 5'h04, 16'h0F0F, 3, "R7/R4 div3 write");
        check(rise_t[1] - rise_t[0] == 8, "R7 MDC period", rise_t[1] - rise_t[0], 8);

        // R8: abort a read
        phy_data = 16'hFFFF;
        r = 0;
        reg_wr(3'd1, 32'd1);
        repeat (50) @(negedge clk);
        reg_wr(3'd0, 32'h8000_0000);
        reg_rd(3'd5, v);
        check(v == 0, "R8 abort clears busy and not-valid", v, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 abort idles pins", {mdc, mdio_oe}, 0);
        reg_rd(3'd0, v);
        check(v == 3, "R8 divider kept on abort", v, 3);
        reg_wr(3'd1, 32'd0);
        reg_wr(3'd0, 32'd1);
        do_write(5'h11, 5'h05, 16'hC3C3, 1, "R8 write after abort");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule